// File: doc/BRIEF.md
# Stochastic Neuron with Threshold

This block evaluates one neuron of a stochastic-computing network. Each of its K synapses receives two serial bit streams, an activation stream and a weight stream, whose densities of ones encode values in [0, 1]. A single AND gate per synapse forms the product stream. The block counts the ones produced by all K gates in every cycle and accumulates that count over a window of 2^L sample cycles. The two streams of a synapse must come from generators that are wired independently. If they are correlated, the AND output no longer has the density of the product.

A one-cycle start pulse clears the accumulator and opens a window. The block then samples the streams on exactly 2^L consecutive cycles. After the last sample it raises a one-cycle done pulse. It also sets the decision bit when the accumulated sum reaches the threshold. The sum and the decision stay on the outputs until the next start. Stream generation and the sequencing of layers belong to the surrounding fabric. For example, a hidden neuron fed by 196 inputs uses K = 196 and L between 10 and 19.

Top module: `stoch_neuron`

## Requirements
- R1: After reset, done_o, fire_o and sum_o are all zero.
- R2: A start_i sampled high makes sum_o, fire_o and done_o read zero on the following cycle, and it opens a new window.
- R3: On every sample cycle of a window, sum_o grows by the number of positions i where act_i[i] and wgt_i[i] are both 1. Bit i of one vector pairs only with bit i of the other.
- R4: A window samples the streams on exactly 2^L cycles, beginning the cycle after start_i. done_o is high for exactly one cycle, in the cycle after the last sample.
- R5: In the done_o cycle, fire_o is 1 if and only if sum_o is greater than or equal to thresh_i as sampled on the last sample cycle. An equal value counts as a fire.
- R6: Outside a window, with start_i low, act_i and wgt_i are ignored: sum_o and fire_o hold and done_o stays low.
- R7: A start_i during a window discards the partial sum and begins a full new window. The aborted window produces no done_o pulse.
- R8: sum_o is wide enough to hold K*2^L, so all-ones streams give exactly K*2^L with no wrap.
- R9: After done_o, sum_o and fire_o keep their final values until the next start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the state and opens a window |
| act_i | input | K | One activation stream bit per synapse |
| wgt_i | input | K | One weight stream bit per synapse |
| thresh_i | input | SUM_W | Decision threshold, SUM_W = clog2(K*2^L+1) |
| done_o | output | 1 | One-cycle pulse at the end of a window |
| sum_o | output | SUM_W | Accumulated count of AND ones |
| fire_o | output | 1 | Decision: sum reached the threshold |

## Verification
The bench builds the neuron with K = 8 and L = 3, so each window is 8 cycles and the full-scale sum is 64. This makes the all-ones overflow boundary, the threshold-equal and threshold-plus-one cases, aborted windows and idle stretches all reachable within a few hundred cycles. The stream patterns include complementary vectors whose AND is zero, identical vectors whose AND equals the input, and pseudo-random pairs. Every window result and its completion cycle are checked against counts computed in the bench.

// File: rtl/sn_pkg.sv
package sn_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sn_state_e;
endpackage

// File: rtl/sn_popcount.sv
module sn_popcount #(
  parameter int K  = 196,
  parameter int CW = $clog2(K + 1)
) (
  input  logic [K-1:0]  a_i,
  input  logic [K-1:0]  b_i,
  output logic [CW-1:0] cnt_o
);
  logic [K-1:0] prod;

  // one AND gate per synapse forms the product stream
  genvar g;
  generate
    for (g = 0; g < K; g++) begin : g_mul
      assign prod[g] = a_i[g] & b_i[g];
    end
  endgenerate

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < K; i++) cnt_o = cnt_o + CW'(prod[i]);
  end
endmodule

// File: rtl/sn_window_ctr.sv
module sn_window_ctr
  import sn_pkg::*;
#(
  parameter int L = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic run_o,
  output logic last_o
);
  sn_state_e  state_q;
  logic [L-1:0] cnt_q;

  assign run_o  = (state_q == ST_RUN);
  assign last_o = run_o && (cnt_q == {L{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (run_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/sn_accum.sv
module sn_accum #(
  parameter int SUM_W = 18,
  parameter int CW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             last_i,
  input  logic [CW-1:0]    pc_i,
  input  logic [SUM_W-1:0] thresh_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o,
  output logic             fire_o
);
  logic [SUM_W-1:0] sum_nxt;

  assign sum_nxt = sum_o + SUM_W'(pc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      done_o <= 1'b0;
      fire_o <= 1'b0;
    end else if (start_i) begin
      sum_o  <= '0;
      done_o <= 1'b0;
      fire_o <= 1'b0;
    end else begin
      done_o <= en_i && last_i;
      if (en_i) sum_o <= sum_nxt;
      if (en_i && last_i) fire_o <= (sum_nxt >= thresh_i);
    end
  end
endmodule

// File: rtl/stoch_neuron.sv
module stoch_neuron #(
  parameter  int K     = 196,
  parameter  int L     = 10,
  localparam int SUM_W = $clog2(K * (2 ** L) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [K-1:0]     act_i,
  input  logic [K-1:0]     wgt_i,
  input  logic [SUM_W-1:0] thresh_i,
  output logic             done_o,
  output logic [SUM_W-1:0] sum_o,
  output logic             fire_o
);
  localparam int CW = $clog2(K + 1);

  logic          run;
  logic          last;
  logic [CW-1:0] pc;

  sn_popcount #(.K(K), .CW(CW)) i_pop (
    .a_i  (act_i),
    .b_i  (wgt_i),
    .cnt_o(pc)
  );

  sn_window_ctr #(.L(L)) i_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .run_o  (run),
    .last_o (last)
  );

  sn_accum #(.SUM_W(SUM_W), .CW(CW)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .en_i    (run),
    .last_i  (last),
    .pc_i    (pc),
    .thresh_i(thresh_i),
    .sum_o   (sum_o),
    .done_o  (done_o),
    .fire_o  (fire_o)
  );
endmodule

// File: rtl/sn_checker.sv
module sn_checker #(
  parameter int K     = 196,
  parameter int L     = 10,
  parameter int SUM_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [SUM_W-1:0] thresh_i,
  input logic             run_i,
  input logic             done_i,
  input logic [SUM_W-1:0] sum_i,
  input logic             fire_i
);
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(K * (2 ** L));
  localparam logic [SUM_W-1:0] K_W     = SUM_W'(K);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sum_i == '0 && !fire_i && !done_i));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> ($stable(sum_i) && $stable(fire_i) && !done_i));

  assert_step_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> (sum_i >= $past(sum_i) && (sum_i - $past(sum_i)) <= K_W));

  assert_fire_rule_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (fire_i == (sum_i >= $past(thresh_i))));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_i <= MAX_SUM);
endmodule

bind stoch_neuron sn_checker #(.K(K), .L(L), .SUM_W(SUM_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .thresh_i(thresh_i),
  .run_i   (run),
  .done_i  (done_o),
  .sum_i   (sum_o),
  .fire_i  (fire_o)
);

// File: tb/test_stoch_neuron.sv
`timescale 1ns/1ps
module test_stoch_neuron;
  localparam int K     = 8;
  localparam int L     = 3;
  localparam int N     = 2 ** L;
  localparam int SUM_W = $clog2(K * N + 1);

  typedef struct {
    int sum;
    bit fire;
    int cyc;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [K-1:0]     act = '0;
  logic [K-1:0]     wgt = '0;
  logic [SUM_W-1:0] thresh = '0;
  logic             done;
  logic [SUM_W-1:0] sum;
  logic             fire;

  int   tests = 0;
  int   fails = 0;
  int   cyc = 0;
  int   n_done = 0;
  int   n_exp = 0;
  exp_t exp_q[$];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stoch_neuron #(.K(K), .L(L)) i_stoch_neuron (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .act_i(act), .wgt_i(wgt),
    .thresh_i(thresh), .done_o(done), .sum_o(sum), .fire_o(fire)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic logic [K-1:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[K-1:0];
  endfunction

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R3 window sum", int'(sum), e.sum);
        check("R5 fire decision", int'(fire), int'(e.fire));
        check("R4 done cycle", cyc, e.cyc);
      end
    end
  end

  // pat: 0 random, 1 all ones, 2 act ones wgt zero, 3 complementary, 4 identical
  // thr_kind: 0 thresh=sum, 1 thresh=sum+1, 2 thresh=20; pre: aborted samples first
  task automatic run_window(input int pat, input int thr_kind, input int pre);
    logic [K-1:0] a_s[N];
    logic [K-1:0] w_s[N];
    int   s;
    exp_t e;
    s = 0;
    for (int i = 0; i < N; i++) begin
      case (pat)
        0: begin a_s[i] = next_rand(); w_s[i] = next_rand(); end
        1: begin a_s[i] = '1; w_s[i] = '1; end
        2: begin a_s[i] = '1; w_s[i] = '0; end
        3: begin a_s[i] = next_rand(); w_s[i] = ~a_s[i]; end
        default: begin a_s[i] = next_rand(); w_s[i] = a_s[i]; end
      endcase
      s += $countones(a_s[i] & w_s[i]);
    end
    case (thr_kind)
      0: thresh = SUM_W'(s);
      1: thresh = SUM_W'(s + 1);
      default: thresh = SUM_W'(20);
    endcase
    e.sum  = s;
    e.fire = (s >= int'(thresh));
    if (pre > 0) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < pre; i++) begin
        act = '1; wgt = '1;
        @(negedge clk);
      end
    end
    start = 1'b1;
    act = '1; wgt = '1;
    @(negedge clk);
    start = 1'b0;
    // R2: cleared one cycle after start
    check("R2 sum cleared", int'(sum), 0);
    check("R2 fire cleared", int'(fire), 0);
    e.cyc = cyc + N;
    exp_q.push_back(e);
    n_exp++;
    for (int i = 0; i < N; i++) begin
      act = a_s[i]; wgt = w_s[i];
      @(negedge clk);
    end
    act = '0; wgt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int held_sum;
    int held_fire;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done at reset", int'(done), 0);
    check("R1 sum at reset", int'(sum), 0);
    check("R1 fire at reset", int'(fire), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_window(0, 0, 0);   // R5 equal threshold fires
    @(negedge clk);
    run_window(0, 1, 0);   // R5 threshold one above stays low
    @(negedge clk);
    run_window(1, 0, 0);   // R8 full scale K*2^L
    @(negedge clk);
    run_window(1, 1, 0);   // R8 full scale, no fire at K*2^L+1
    // R9 / R6: hold after done while streams toggle, no start
    @(negedge clk);
    held_sum  = int'(sum);
    held_fire = int'(fire);
    for (int i = 0; i < 6; i++) begin
      act = '1; wgt = '1;
      @(negedge clk);
      check("R6 idle sum held", int'(sum), held_sum);
      check("R9 fire held", int'(fire), held_fire);
      check("R6 no done while idle", int'(done), 0);
    end
    act = '0; wgt = '0;
    run_window(2, 2, 0);   // R3 AND with zero weights
    run_window(3, 0, 0);   // R3 complementary pairs give zero
    run_window(4, 2, 0);   // R3 identical streams
    run_window(0, 2, 3);   // R7 restart after 3 samples
    run_window(1, 2, N - 1); // R7 restart at last sample
    run_window(0, 2, 0);   // back to back
    repeat (4) @(negedge clk);
    check("R4 all windows completed", n_done, n_exp);
    check("R4 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule